// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

The scanner walks a 4x4 key matrix. It pulls one row line low at a time and reads four active-low column lines. If a column reads low while its row is driven, the key at that crossing looks pressed. The scanner then waits a fixed number of clock cycles and reads the same column again. It accepts the key only if the column is still low.

An accepted key is reported as a 4-bit hexadecimal code together with a strobe that lasts one cycle. The scanner then stays on that row until every column reads high again, so each physical press gives exactly one code. Column lines come from the outside world, so they pass through a two-flop synchroniser. After every row change, the scanner waits for that synchroniser to refill before it reads any column.

Top module: `keypad_scan`

## Requirements
- R1: Exactly one bit of `row_n` is 0 at any time; the other three are 1.
- R2: While and after reset, `row_n` is 4'b1110 (row 0 driven) and `key_valid` is 0.
- R3: With no key pressed, the driven row advances 0, 1, 2, 3, 0, ... without end.
- R4: Row i is driven by `row_n[i]` = 0, and the key at row i, column j pulls `col_n[j]` low. Its reported code is 4*i + j, so row 0 holds codes 0 to 3.
- R5: A key is reported only if its column is still low when rechecked SETTLE_CYCLES cycles after first detection. A press shorter than that interval produces no code.
- R6: `key_valid` is high for one cycle per accepted key, with `key_code` valid in that cycle.
- R7: After a report, the driven row stays fixed until all columns read high, and one press yields one code however long it is held.
- R8: When a recheck fails, scanning resumes at the next column of the same row. A key held steadily in a later column of that row is still reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_n | output | 4 | Row drive, active low, one-hot |
| col_n | input | 4 | Column sense, active low, asynchronous |
| key_code | output | 4 | Code of the accepted key |
| key_valid | output | 1 | One-cycle strobe marking a new code |

## Verification
A corrupted row or column index shows up as a code that does not match the pressed key. It appears at the strobe, one settle interval after detection. A broken state sequence shows up at the row pins within a few cycles: more than one row driven low, rows skipped, or the row moving while a key is still held. A wrong settle count or a missing recheck lets short presses through as strobes. A missing release wait turns a long press into repeated strobes within one scan period.

// File: rtl/keypad_scan.sv
module keypad_scan #(
  parameter int SETTLE_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [3:0] row_n,
  input  logic [3:0] col_n,
  output logic [3:0] key_code,
  output logic       key_valid
);

  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  typedef enum logic [1:0] {S_ROW, S_COL, S_WAIT, S_HOLD} st_t;

  st_t           st;
  logic [3:0]    sync1, col_s;
  logic [1:0]    row, col;
  logic [CW-1:0] cnt;

  assign row_n = ~(4'b0001 << row);
  wire hit = ~col_s[col];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1     <= 4'hF;
      col_s     <= 4'hF;
      row       <= 2'd0;
      col       <= 2'd0;
      cnt       <= '0;
      st        <= S_ROW;
      key_valid <= 1'b0;
      key_code  <= 4'h0;
    end else begin
      sync1     <= col_n;
      col_s     <= sync1;
      key_valid <= 1'b0;
      case (st)
        S_ROW: begin
          if (cnt == CW'(1)) begin
            cnt <= '0;
            st  <= S_COL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_COL: begin
          if (hit) begin
            cnt <= '0;
            st  <= S_WAIT;
          end else if (col == 2'd3) begin
            col <= 2'd0;
            row <= row + 1'b1;
            st  <= S_ROW;
          end else begin
            col <= col + 1'b1;
          end
        end
        S_WAIT: begin
          if (cnt == CW'(SETTLE_CYCLES - 1)) begin
            cnt <= '0;
            if (hit) begin
              key_valid <= 1'b1;
              key_code  <= {row, col};
              st        <= S_HOLD;
            end else if (col == 2'd3) begin
              col <= 2'd0;
              row <= row + 1'b1;
              st  <= S_ROW;
            end else begin
              col <= col + 1'b1;
              st  <= S_COL;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (&col_s) begin
            col <= 2'd0;
            row <= row + 1'b1;
            st  <= S_ROW;
          end
        end
        default: st <= S_ROW;
      endcase
    end
  end

  assert_one_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_n) == 1);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  assert_code_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> !row_n[key_code[3:2]]);

  assert_recheck_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> ((~$past(col_s) & (4'b0001 << key_code[1:0])) != 4'h0));

  assert_hold_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && !(&col_s)) |=> $stable(row_n));

endmodule

// File: tb/keypad_scan_tb.sv
module keypad_scan_tb_top;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] row_n, col_n, key_code;
  logic key_valid;
  logic [15:0] key_dn = 16'h0;

  int checks = 0, fails = 0, pulses = 0, dbl = 0;
  logic [3:0] last_code = 4'h0;
  logic prev_valid = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keypad_scan #(.SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .col_n(col_n),
    .key_code(key_code), .key_valid(key_valid)
  );

  always_comb begin
    for (int j = 0; j < 4; j++) begin
      col_n[j] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (key_dn[r*4+j] && !row_n[r]) col_n[j] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (key_valid) begin
      pulses++;
      last_code = key_code;
      if (prev_valid) dbl++;
    end
    prev_valid = key_valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic int row_idx(input logic [3:0] r);
    for (int i = 0; i < 4; i++) if (!r[i]) return i;
    return -1;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(row_n == 4'b1110, "R2 row in reset", row_n, 4'b1110);
    chk(key_valid == 1'b0, "R2 valid in reset", key_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(row_n == 4'b1110, "R2 row after reset", row_n, 4'b1110);
    chk(key_valid == 1'b0, "R2 valid after reset", key_valid, 0);
  endtask

  task automatic t_idle_scan();
    int bad = 0, steps = 0, wrong = 0;
    int prev = row_idx(row_n);
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if ($countones(~row_n) != 1) bad++;
      if (row_idx(row_n) != prev) begin
        if (row_idx(row_n) != (prev + 1) % 4) wrong++;
        steps++;
        prev = row_idx(row_n);
      end
    end
    chk(bad == 0, "R1 one row low", bad, 0);
    chk(wrong == 0, "R3 row order", wrong, 0);
    chk(steps >= 8, "R3 rows keep cycling", steps, 8);
    chk(pulses == 0, "R3 no code when idle", pulses, 0);
  endtask

  task automatic t_press(input int k, input int hold);
    pulses = 0;
    key_dn[k] = 1'b1;
    repeat (hold) @(negedge clk);
    chk(row_n[k/4] == 1'b0, "R7 row held while pressed", row_n, ~(4'b1 << (k/4)) & 4'hF);
    key_dn[k] = 1'b0;
    repeat (60) @(negedge clk);
    chk(pulses == 1, "R7 one code per press", pulses, 1);
    chk(last_code == 4'(k), "R4 key code", last_code, k);
  endtask

  task automatic t_glitch();
    pulses = 0;
    key_dn[6] = 1'b1;
    repeat (12) @(negedge clk);
    key_dn[6] = 1'b0;
    repeat (80) @(negedge clk);
    chk(pulses == 0, "R5 short press rejected", pulses, 0);
  endtask

  task automatic t_glitch_then_steady();
    pulses = 0;
    key_dn[4] = 1'b1;
    key_dn[7] = 1'b1;
    repeat (12) @(negedge clk);
    key_dn[4] = 1'b0;
    repeat (150) @(negedge clk);
    key_dn[7] = 1'b0;
    repeat (60) @(negedge clk);
    chk(pulses == 1, "R8 steady key after failed recheck", pulses, 1);
    chk(last_code == 4'h7, "R8 code of steady key", last_code, 7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    t_reset();
    t_idle_scan();
    t_press(0, 100);
    t_press(5, 100);
    t_press(10, 100);
    t_press(15, 200);
    t_press(3, 100);
    t_press(12, 100);
    t_glitch();
    t_glitch_then_steady();
    chk(dbl == 0, "R6 strobe one cycle", dbl, 0);
    finish_run();
  end
endmodule